// File: doc/BRIEF.md
# Dual-Mode Serial ECC/CRC Shift Register

This block divides a serial bit stream by a generator polynomial, one bit per bit-clock enable, with no processor involvement. One shift register serves two field types: a 32-bit burst-correcting code over the data field of a sector, and a 16-bit CRC over each sector header. The read/write serialiser feeds it field bits. A side input marks the check-bit tail that follows the field.

In generate mode, used for writes, the field bits pass straight through to the serial output. During the tail the register empties itself onto that output, most significant bit first. In check mode, used for reads, the received check bits are divided like any other bits. A zero final remainder means the sector arrived intact. Firmware reads the remainder word to find the error position and pattern. A clear at the start of each field latches the field type and direction and presets the register.

Top module: `ecc_crc_shifter`

## Requirements
- R1: After reset the remainder is 0, the zero flag is 1, the tail-done flag is 0, and data mode in check direction is selected.
- R2: When `clear_i` is high, the next edge latches `mode_i` (0 = data, 1 = header) and `gen_i` (1 = generate, 0 = check). It presets the remainder to 0xFFFF in header mode and to `DATA_INIT` (default 0) in data mode, and clears the tail count.
- R3: Header mode divides MSB-first by x^16+x^12+x^5+1 over a 16-bit register. Feeding the ASCII bytes "123456789", each MSB first, after the preset leaves remainder 0x29B1. Bits 31..16 of the remainder read 0 in header mode.
- R4: Data mode divides MSB-first by the 32-bit polynomial `DATA_POLY`. Its default is x^32+x^23+x^21+x^11+x^2+1 (low-order taps 0x00A00805).
- R5: While `bit_en_i` and `clear_i` are low, the remainder and tail count hold, whatever `din_i` does.
- R6: In generate mode with `tail_i` high, each enabled bit puts the remainder's top active bit on `ser_o` and shifts the register left with zero fill and no feedback. At all other times `ser_o` equals `din_i`.
- R7: In check mode, tail bits are divided like field bits. `zero_o` is 1 exactly when the remainder is zero.
- R8: `done_o` goes high once the active width's worth of enabled tail bits (16 or 32) has been counted since the last clear, and stays high until the next clear.
- R9: Changes on `mode_i` or `gen_i` between clears have no effect.
- R10: A clear in the same cycle as `bit_en_i` presets the register, and that bit is not divided.
- R11: In data mode, a 512-byte field with its 32 check bits, read back with an error burst of up to 11 bits, gives a nonzero remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Preset for a new field; latches mode_i and gen_i |
| mode_i | input | 1 | Field type: 0 data code, 1 header CRC |
| gen_i | input | 1 | Direction: 1 generate (write), 0 check (read) |
| bit_en_i | input | 1 | Bit-clock enable, one serial bit per pulse |
| din_i | input | 1 | Serial bit from the serialiser |
| tail_i | input | 1 | High while the check-bit tail is passing |
| ser_o | output | 1 | Serial out: din_i, or check bits during a generate tail |
| rem_o | output | DATA_W | Current remainder, upper 16 bits zero in header mode |
| zero_o | output | 1 | Remainder is zero |
| done_o | output | 1 | All check bits of the active width counted |

## Verification
`ser_o` is combinational and valid in the same cycle as its inputs, so the bench samples it 1 ns after driving. `rem_o`, `zero_o` and `done_o` are one register stage behind an enabled bit or a clear. The bench samples them at the falling edge after the rising edge that took the stimulus. A behavioural model, updated at that same rising edge, supplies every expected value. The known header-CRC value, the serialised tail, the zero remainder on a clean read-back and the nonzero remainder after an 11-bit burst are each checked on their own as well.

// File: rtl/ecc_crc_pkg.sv
package ecc_crc_pkg;
  typedef enum logic {
    FLD_DATA = 1'b0,
    FLD_HDR  = 1'b1
  } fld_e;

  localparam int unsigned HDR_W    = 16;
  localparam logic [15:0] HDR_POLY = 16'h1021;
  localparam logic [15:0] HDR_INIT = 16'hFFFF;
endpackage

// File: rtl/ecc_poly_sel.sv
module ecc_poly_sel
  import ecc_crc_pkg::*;
#(
  parameter int unsigned W         = 32,
  parameter logic [W-1:0] DATA_POLY = 32'h00A0_0805,
  parameter logic [W-1:0] DATA_INIT = '0
) (
  input  fld_e         fld_i,
  output logic [W-1:0] poly_o,
  output logic [W-1:0] init_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] top_o
);
  localparam int unsigned PAD = W - HDR_W;

  always_comb begin
    if (fld_i == FLD_HDR) begin
      poly_o = {{PAD{1'b0}}, HDR_POLY};
      init_o = {{PAD{1'b0}}, HDR_INIT};
      mask_o = {{PAD{1'b0}}, {HDR_W{1'b1}}};
      top_o  = '0;
      top_o[HDR_W-1] = 1'b1;
    end else begin
      poly_o = DATA_POLY;
      init_o = DATA_INIT;
      mask_o = '1;
      top_o  = '0;
      top_o[W-1] = 1'b1;
    end
  end
endmodule

// File: rtl/ecc_lfsr_core.sv
module ecc_lfsr_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] init_i,
  input  logic         en_i,
  input  logic         din_i,
  input  logic         nofb_i,
  input  logic [W-1:0] poly_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] rem_o,
  output logic         msb_o
);
  logic [W-1:0] q;
  logic [W-1:0] shl;
  logic [W-1:0] nxt;
  logic         fb;

  for (genvar i = 0; i < W; i++) begin : g_shift
    if (i == 0) begin : g_lsb
      assign shl[i] = 1'b0;
    end else begin : g_mid
      assign shl[i] = q[i-1];
    end
  end

  assign msb_o = |(q & top_i);
  // generate tail: plain shift-out, no division
  assign fb    = nofb_i ? 1'b0 : (msb_o ^ din_i);
  assign nxt   = (shl ^ (poly_i & {W{fb}})) & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (clr_i)   q <= init_i & mask_i;
    else if (en_i)    q <= nxt;
  end

  assign rem_o = q;
endmodule

// File: rtl/ecc_tail_ctr.sv
module ecc_tail_ctr #(
  parameter int unsigned MAXN = 32,
  localparam int unsigned CW  = $clog2(MAXN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt <= '0;
    else if (clr_i)                  cnt <= '0;
    else if (step_i && cnt < limit_i) cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == limit_i);
endmodule

// File: rtl/ecc_crc_shifter.sv
module ecc_crc_shifter
  import ecc_crc_pkg::*;
#(
  parameter int unsigned  DATA_W    = 32,
  parameter logic [DATA_W-1:0] DATA_POLY = 32'h00A0_0805,
  parameter logic [DATA_W-1:0] DATA_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              mode_i,
  input  logic              gen_i,
  input  logic              bit_en_i,
  input  logic              din_i,
  input  logic              tail_i,
  output logic              ser_o,
  output logic [DATA_W-1:0] rem_o,
  output logic              zero_o,
  output logic              done_o
);
  localparam int unsigned CW = $clog2(DATA_W + 1);

  fld_e              fld_q;
  logic              hdr_q;
  logic              gen_q;
  logic [DATA_W-1:0] poly, init, mask, top;
  logic              msb;
  logic              wtail;
  logic [CW-1:0]     limit;

  // field type and direction fixed per field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q <= FLD_DATA;
      gen_q <= 1'b0;
    end else if (clear_i) begin
      fld_q <= fld_e'(mode_i);
      gen_q <= gen_i;
    end
  end

  assign hdr_q = (fld_q == FLD_HDR);
  assign wtail = gen_q && tail_i;
  assign limit = hdr_q ? CW'(HDR_W) : CW'(DATA_W);

  ecc_poly_sel #(
    .W(DATA_W), .DATA_POLY(DATA_POLY), .DATA_INIT(DATA_INIT)
  ) u_sel (
    .fld_i (fld_q),
    .poly_o(poly),
    .init_o(init),
    .mask_o(mask),
    .top_o (top)
  );

  // preset on clear uses the incoming mode, not the latched one
  logic [DATA_W-1:0] init_new, mask_new;
  logic [DATA_W-1:0] poly_unused, top_unused;
  ecc_poly_sel #(
    .W(DATA_W), .DATA_POLY(DATA_POLY), .DATA_INIT(DATA_INIT)
  ) u_sel_new (
    .fld_i (fld_e'(mode_i)),
    .poly_o(poly_unused),
    .init_o(init_new),
    .mask_o(mask_new),
    .top_o (top_unused)
  );

  logic [DATA_W-1:0] core_mask;
  assign core_mask = clear_i ? mask_new : mask;

  ecc_lfsr_core #(.W(DATA_W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clear_i),
    .init_i(init_new),
    .en_i  (bit_en_i),
    .din_i (din_i),
    .nofb_i(wtail),
    .poly_i(poly),
    .mask_i(core_mask),
    .top_i (top),
    .rem_o (rem_o),
    .msb_o (msb)
  );

  ecc_tail_ctr #(.MAXN(DATA_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clear_i),
    .step_i (bit_en_i && tail_i),
    .limit_i(limit),
    .done_o (done_o)
  );

  assign ser_o  = wtail ? msb : din_i;
  assign zero_o = (rem_o == '0);

  logic unused_ok;
  assign unused_ok = ^{poly_unused, top_unused};
endmodule

// File: rtl/ecc_crc_shifter_chk.sv
module ecc_crc_shifter_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clear_i,
  input logic         mode_i,
  input logic         bit_en_i,
  input logic         tail_i,
  input logic [W-1:0] rem_o,
  input logic         done_o,
  input logic         zero_o,
  input logic         hdr_q,
  input logic         gen_q
);
  localparam logic [W-1:0] HMASK = {{(W-16){1'b0}}, 16'hFFFF};

  // R5
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_en_i && !clear_i) |=> $stable(rem_o));

  // R2
  hdr_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && mode_i) |=> (rem_o == HMASK));

  // R8
  done_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !done_o);

  // R3
  hdr_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_q |-> ((rem_o & ~HMASK) == '0));

  // R6
  tail_shift_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !clear_i && tail_i && gen_q && hdr_q) |=>
      (rem_o == (($past(rem_o) << 1) & HMASK)));

  // R7
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o == (rem_o == '0));
endmodule

bind ecc_crc_shifter ecc_crc_shifter_chk #(.W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clear_i (clear_i),
  .mode_i  (mode_i),
  .bit_en_i(bit_en_i),
  .tail_i  (tail_i),
  .rem_o   (rem_o),
  .done_o  (done_o),
  .zero_o  (zero_o),
  .hdr_q   (hdr_q),
  .gen_q   (gen_q)
);

// File: tb/ecc_crc_shifter_bench.sv
`timescale 1ns/1ps
module ecc_crc_shifter_bench;
  localparam int unsigned W = 32;
  localparam logic [31:0] DPOLY = 32'h00A0_0805;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0, mode_i = 1'b0, gen_i = 1'b0;
  logic bit_en_i = 1'b0, din_i = 1'b0, tail_i = 1'b0;
  logic ser_o, zero_o, done_o;
  logic [W-1:0] rem_o;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // behavioural model state
  logic [31:0] m_rem = '0;
  bit m_hdr = 0, m_gen = 0;
  int m_cnt = 0;

  logic [31:0] cap;
  byte sector [512];

  always #2.5 clk = ~clk;

  ecc_crc_shifter u_ecc_crc_shifter (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .mode_i(mode_i),
    .gen_i(gen_i), .bit_en_i(bit_en_i), .din_i(din_i), .tail_i(tail_i),
    .ser_o(ser_o), .rem_o(rem_o), .zero_o(zero_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int width();
    return m_hdr ? 16 : 32;
  endfunction

  task automatic model_edge(input bit en, input bit d, input bit t, input bit clr,
                            input bit md, input bit g);
    int w;
    bit top, fb;
    logic [31:0] p, msk;
    if (clr) begin
      m_hdr = md; m_gen = g; m_cnt = 0;
      m_rem = md ? 32'h0000FFFF : 32'h0;
    end else if (en) begin
      w   = width();
      msk = (w == 16) ? 32'h0000FFFF : 32'hFFFFFFFF;
      p   = (w == 16) ? 32'h00001021 : DPOLY;
      top = m_rem[w-1];
      fb  = (m_gen && t) ? 1'b0 : (top ^ d);
      m_rem = (m_rem << 1) & msk;
      if (fb) m_rem = m_rem ^ p;
      if (t && m_cnt < w) m_cnt++;
    end
  endtask

  // one clock: drive at negedge, check comb at +1ns, registered at next negedge
  task automatic step(input bit en, input bit d, input bit t, input bit clr);
    logic exp_ser;
    bit_en_i = en; din_i = d; tail_i = t; clear_i = clr;
    #1;
    exp_ser = (m_gen && t) ? m_rem[width()-1] : d;
    chk(ser_o === exp_ser, "R6 ser_o", {31'b0, ser_o}, {31'b0, exp_ser});
    if (m_gen && t && en && !clr) cap = {cap[30:0], ser_o};
    @(posedge clk);
    model_edge(en, d, t, clr, mode_i, gen_i);
    @(negedge clk);
    chk(rem_o === m_rem, m_hdr ? "R3 rem_o" : "R4 rem_o", rem_o, m_rem);
    chk(zero_o === (m_rem == 0), "R7 zero_o", {31'b0, zero_o}, {31'b0, (m_rem == 0)});
    chk(done_o === (m_cnt == width()), "R8 done_o", {31'b0, done_o},
        {31'b0, (m_cnt == width())});
  endtask

  task automatic feed_byte(input byte b);
    for (int i = 7; i >= 0; i--) step(1'b1, b[i], 1'b0, 1'b0);
  endtask

  task automatic feed_word(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) step(1'b1, v[i], 1'b1, 1'b0);
  endtask

  task automatic start(input bit md, input bit g);
    mode_i = md; gen_i = g;
    step(1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL all watchdog actual=%0d expected<150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    string s9;
    logic [31:0] dcheck;
    s9 = "123456789";
    for (int i = 0; i < 512; i++) sector[i] = byte'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk(rem_o === '0, "R1 rem", rem_o, 32'h0);
    chk(zero_o === 1'b1, "R1 zero", {31'b0, zero_o}, 32'h1);
    chk(done_o === 1'b0, "R1 done", {31'b0, done_o}, 32'h0);
    @(negedge clk);

    // R2 / R3: header generate, known check value, tail out MSB first
    start(1'b1, 1'b1);
    chk(rem_o === 32'h0000FFFF, "R2 hdr preset", rem_o, 32'h0000FFFF);
    for (int i = 0; i < 9; i++) feed_byte(s9[i]);
    chk(rem_o === 32'h000029B1, "R3 crc 123456789", rem_o, 32'h000029B1);
    // R5 idle with toggling data
    for (int i = 0; i < 6; i++) step(1'b0, i[0], 1'b0, 1'b0);
    chk(rem_o === 32'h000029B1, "R5 hold", rem_o, 32'h000029B1);
    // R9 mode/gen changes mid-field ignored
    mode_i = 1'b0; gen_i = 1'b0;
    cap = '0;
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
    chk(cap[15:0] === 16'h29B1, "R6 R9 tail bits", {16'b0, cap[15:0]}, 32'h29B1);
    chk(done_o === 1'b1, "R8 hdr done", {31'b0, done_o}, 32'h1);
    chk(rem_o === 32'h0, "R6 emptied", rem_o, 32'h0);

    // R7 header read-back clean and corrupted
    start(1'b1, 1'b0);
    for (int i = 0; i < 9; i++) feed_byte(s9[i]);
    feed_word(32'h29B1, 16);
    chk(zero_o === 1'b1, "R7 hdr clean", {31'b0, zero_o}, 32'h1);
    start(1'b1, 1'b0);
    for (int i = 0; i < 9; i++) feed_byte(i == 4 ? (s9[i] ^ 8'h10) : s9[i]);
    feed_word(32'h29B1, 16);
    chk(zero_o === 1'b0, "R7 hdr bad", {31'b0, zero_o}, 32'h0);

    // R10 clear with bit_en: bit not divided
    mode_i = 1'b1; gen_i = 1'b0;
    step(1'b1, 1'b1, 1'b0, 1'b1);
    chk(rem_o === 32'h0000FFFF, "R10 clear wins", rem_o, 32'h0000FFFF);

    // R4 data generate over 512 bytes
    start(1'b0, 1'b1);
    chk(rem_o === 32'h0, "R2 data preset", rem_o, 32'h0);
    for (int i = 0; i < 512; i++) feed_byte(sector[i]);
    dcheck = rem_o;
    cap = '0;
    for (int i = 0; i < 32; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
    chk(cap === dcheck, "R4 R6 data tail", cap, dcheck);
    chk(done_o === 1'b1, "R8 data done", {31'b0, done_o}, 32'h1);

    // R7 data clean read
    start(1'b0, 1'b0);
    for (int i = 0; i < 512; i++) feed_byte(sector[i]);
    feed_word(dcheck, 32);
    chk(zero_o === 1'b1, "R7 data clean", {31'b0, zero_o}, 32'h1);

    // R11 11-bit burst
    start(1'b0, 1'b0);
    for (int i = 0; i < 512; i++) begin
      if (i == 200)      feed_byte(sector[i] ^ 8'h81);
      else if (i == 201) feed_byte(sector[i] ^ 8'hE0);
      else               feed_byte(sector[i]);
    end
    feed_word(dcheck, 32);
    chk(zero_o === 1'b0, "R11 burst detect", {31'b0, zero_o}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule